// File: doc/BRIEF.md
# FIFO Watermark and Word Counter

This block sits beside a FIFO that serves a serial channel in both directions. From the current transmit and receive occupancies it derives two level requests. The receive request means the buffer already holds enough bytes to be drained. The transmit request means the buffer has enough free room to be refilled. Each threshold is programmed as its byte count minus one. The block also counts completed words against a programmed total and raises an end-of-count event when that total is reached. While a count is running, the readback of the count field shows the live word index.

Six events feed a sticky status vector: transmit almost-empty, transmit underflow, receive almost-full, receive overflow, wake-up and end of count. Software clears a status bit by writing 1 to it. Each bit has its own enable, and the enabled bits are ORed into one interrupt line. The FIFO storage and the serial shifter are outside the block. The underflow, overflow and wake-up conditions arrive from them as single-cycle pulses.

Top module: `fifo_wm_ctrl`

## Requirements
- R1: `rx_req` is high exactly when `chan_en` is high and `rx_level` >= `af_lvl` + 1.
- R2: `tx_req` is high exactly when `chan_en` is high and (DEPTH - `tx_level`) >= `ae_lvl` + 1.
- R3: Status bit 0 (transmit almost-empty) and status bit 2 (receive almost-full) are set in the cycle after their request rises. A request that stays high does not set its bit again after the bit has been cleared.
- R4: A cycle with `evt_wr` high clears every status bit whose `evt_wdata` bit is 1 and leaves the bits written 0 unchanged. A set and a clear of the same bit in the same cycle leave the bit at 1.
- R5: `irq` is high exactly when some bit of `evt_status` AND `evt_en` is 1.
- R6: While the programmed word total is 0, `word_done` pulses have no effect: `wcnt_rd` reads 0 and status bit 5 never sets.
- R7: `wcnt_rd` returns the programmed total until the first word is counted. From then on it returns the number of words counted so far.
- R8: When the counted words reach the programmed total, status bit 5 (end of count) sets. The index then holds at the total and further `word_done` pulses are ignored.
- R9: Dropping `chan_en` or writing the count field (`wcnt_wr`) clears the index, and `wcnt_rd` then returns the programmed total. A write takes priority over a `word_done` in the same cycle.
- R10: Pulses on `txudf_pulse`, `rxovf_pulse` and `wake_pulse` set status bits 1, 3 and 4 respectively in the next cycle.
- R11: After reset, `evt_status` is 0, `irq` is 0 and `wcnt_rd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel active |
| tx_level | input | OCC_W | Transmit FIFO occupancy in bytes |
| rx_level | input | OCC_W | Receive FIFO occupancy in bytes |
| ae_lvl | input | LVL_W | Almost-empty threshold, room minus one |
| af_lvl | input | LVL_W | Almost-full threshold, bytes minus one |
| txudf_pulse | input | 1 | Transmit underflow pulse |
| rxovf_pulse | input | 1 | Receive overflow pulse |
| wake_pulse | input | 1 | Wake-up pulse |
| word_done | input | 1 | One word transferred |
| wcnt_wr | input | 1 | Write strobe for the word total |
| wcnt_wdata | input | CNT_W | New word total, 0 disables counting |
| evt_wr | input | 1 | Write strobe for the status register |
| evt_wdata | input | 6 | Write-1-to-clear mask |
| evt_en | input | 6 | Per-event interrupt enables |
| tx_req | output | 1 | Transmit almost-empty request |
| rx_req | output | 1 | Receive almost-full request |
| evt_status | output | 6 | Sticky event status |
| irq | output | 1 | Interrupt line |
| wcnt_rd | output | CNT_W | Word count readback |

## Verification
The bench drives each threshold at exactly n-1 and n. A comparator that dropped the +1 or compared the wrong way would move a request one byte early or late. It clears a status bit while its condition stays high and raises a condition in the same cycle as a clear. A level-set design would re-raise the bit, and a clear-wins design would lose the event. The bench also runs a total of zero, counts past the total, and disables or rewrites in the middle of a count. These expose a counter that wraps, keeps counting after the end, fires on a zero total, or shows a stale index after a restart. Random mixes of all inputs are then checked against a cycle model built from the requirements.

// File: rtl/fwm_pkg.sv
package fwm_pkg;
  localparam int NUM_EV    = 6;
  localparam int EV_TX_AE  = 0;
  localparam int EV_TX_UDF = 1;
  localparam int EV_RX_AF  = 2;
  localparam int EV_RX_OVF = 3;
  localparam int EV_WAKE   = 4;
  localparam int EV_EOW    = 5;
  typedef logic [NUM_EV-1:0] evt_vec_t;
endpackage

// File: rtl/fwm_level_cmp.sv
module fwm_level_cmp #(
  parameter int DEPTH = 32,
  parameter int OCC_W = 6,
  parameter int LVL_W = 8,
  parameter bit ROOM  = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [OCC_W-1:0] occ_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic             cond_o,
  output logic             rise_o
);
  localparam int CW = ((OCC_W > LVL_W) ? OCC_W : LVL_W) + 1;

  logic [CW-1:0] have;
  logic [CW-1:0] need;
  logic          cond_q;
  logic          cond_d;

  generate
    if (ROOM) begin : g_room
      assign have = CW'(DEPTH) - CW'(occ_i);
    end else begin : g_fill
      assign have = CW'(occ_i);
    end
  endgenerate

  assign need   = CW'(lvl_i) + CW'(1);
  assign cond_o = en_i & (have >= need);
  assign rise_o = cond_o & ~cond_q;

  always_comb begin
    cond_d = cond_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cond_q <= 1'b0;
    else        cond_q <= cond_d;
  end

  // R3
  rise_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/fwm_word_ctr.sv
module fwm_word_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             done_i,
  output logic             eow_o,
  output logic [CNT_W-1:0] rd_o
);
  logic [CNT_W-1:0] prog_q, prog_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic             run_q, run_d;
  logic [CNT_W-1:0] idx_inc;
  logic             at_end;
  logic             count_ok;
  logic             ce;

  assign idx_inc  = idx_q + CNT_W'(1);
  assign at_end   = (idx_q == prog_q);
  assign count_ok = en_i & done_i & ~wr_i & (prog_q != '0) & ~at_end;
  assign eow_o    = count_ok & (idx_inc == prog_q);
  assign ce       = wr_i | ~en_i | count_ok;
  assign rd_o     = run_q ? idx_q : prog_q;

  always_comb begin
    prog_d = prog_q;
    idx_d  = idx_q;
    run_d  = run_q;
    if (wr_i) begin
      prog_d = wdata_i;
      idx_d  = '0;
      run_d  = 1'b0;
    end else if (!en_i) begin
      idx_d  = '0;
      run_d  = 1'b0;
    end else if (count_ok) begin
      idx_d  = idx_inc;
      run_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q <= '0;
      idx_q  <= '0;
      run_q  <= 1'b0;
    end else if (ce) begin
      prog_q <= prog_d;
      idx_q  <= idx_d;
      run_q  <= run_d;
    end
  end

  // R8
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_q != '0) |-> (idx_q <= prog_q));
  // R6
  zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_q == '0) |-> !eow_o);
  // R9
  disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (idx_q == '0));
endmodule

// File: rtl/fwm_evt_regs.sv
module fwm_evt_regs #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] sts_o,
  output logic         irq_o
);
  logic [N-1:0] sts_q;
  logic [N-1:0] clr;

  assign clr   = wr_i ? wdata_i : '0;
  assign sts_o = sts_q;
  assign irq_o = |(sts_q & en_i);

  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      logic d;
      logic ce;
      assign ce = set_i[i] | clr[i];
      always_comb begin
        d = set_i[i] ? 1'b1 : 1'b0;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  sts_q[i] <= 1'b0;
        else if (ce) sts_q[i] <= d;
      end

      // R4
      set_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[i] |=> sts_q[i]);
      // R4
      clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[i] && !set_i[i]) |=> !sts_q[i]);
      // R4
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr[i] && !set_i[i]) |=> $stable(sts_q[i]));
    end
  endgenerate
endmodule

// File: rtl/fifo_wm_ctrl.sv
module fifo_wm_ctrl
  import fwm_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LVL_W = 8,
  parameter int CNT_W = 16,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_en,
  input  logic [OCC_W-1:0] tx_level,
  input  logic [OCC_W-1:0] rx_level,
  input  logic [LVL_W-1:0] ae_lvl,
  input  logic [LVL_W-1:0] af_lvl,
  input  logic             txudf_pulse,
  input  logic             rxovf_pulse,
  input  logic             wake_pulse,
  input  logic             word_done,
  input  logic             wcnt_wr,
  input  logic [CNT_W-1:0] wcnt_wdata,
  input  logic             evt_wr,
  input  logic [5:0]       evt_wdata,
  input  logic [5:0]       evt_en,
  output logic             tx_req,
  output logic             rx_req,
  output logic [5:0]       evt_status,
  output logic             irq,
  output logic [CNT_W-1:0] wcnt_rd
);
  logic     rst_meta, rst_sync;
  logic     tx_rise, rx_rise, eow;
  evt_vec_t set_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  fwm_level_cmp #(.DEPTH(DEPTH), .OCC_W(OCC_W), .LVL_W(LVL_W), .ROOM(1'b1)) u_tx_cmp (
    .clk(clk), .rst_n(rst_sync), .en_i(chan_en), .occ_i(tx_level),
    .lvl_i(ae_lvl), .cond_o(tx_req), .rise_o(tx_rise));

  fwm_level_cmp #(.DEPTH(DEPTH), .OCC_W(OCC_W), .LVL_W(LVL_W), .ROOM(1'b0)) u_rx_cmp (
    .clk(clk), .rst_n(rst_sync), .en_i(chan_en), .occ_i(rx_level),
    .lvl_i(af_lvl), .cond_o(rx_req), .rise_o(rx_rise));

  fwm_word_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_sync), .en_i(chan_en), .wr_i(wcnt_wr),
    .wdata_i(wcnt_wdata), .done_i(word_done), .eow_o(eow), .rd_o(wcnt_rd));

  always_comb begin
    set_vec            = '0;
    set_vec[EV_TX_AE]  = tx_rise;
    set_vec[EV_TX_UDF] = txudf_pulse;
    set_vec[EV_RX_AF]  = rx_rise;
    set_vec[EV_RX_OVF] = rxovf_pulse;
    set_vec[EV_WAKE]   = wake_pulse;
    set_vec[EV_EOW]    = eow;
  end

  fwm_evt_regs #(.N(NUM_EV)) u_evt (
    .clk(clk), .rst_n(rst_sync), .set_i(set_vec), .wr_i(evt_wr),
    .wdata_i(evt_wdata), .en_i(evt_en), .sts_o(evt_status), .irq_o(irq));

  // R5
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (evt_en == '0) |-> !irq);
  // R10
  udf_set_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    txudf_pulse |=> evt_status[EV_TX_UDF]);
  // R10
  wake_set_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    wake_pulse |=> evt_status[EV_WAKE]);
endmodule

// File: tb/tb_fifo_wm_ctrl.sv
module tb_fifo_wm_ctrl;
  localparam int DEPTH = 32;
  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic chan_en;
  logic [OCC_W-1:0] tx_level, rx_level;
  logic [7:0] ae_lvl, af_lvl;
  logic txudf_pulse, rxovf_pulse, wake_pulse, word_done;
  logic wcnt_wr;
  logic [CNT_W-1:0] wcnt_wdata;
  logic evt_wr;
  logic [5:0] evt_wdata, evt_en;
  logic tx_req, rx_req, irq;
  logic [5:0] evt_status;
  logic [CNT_W-1:0] wcnt_rd;

  int checks = 0;
  int errors = 0;

  logic [5:0] m_sts;
  logic m_txc_q, m_rxc_q, m_run;
  int m_prog, m_idx;

  always #2 clk = ~clk;

  fifo_wm_ctrl #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .tx_level(tx_level),
    .rx_level(rx_level), .ae_lvl(ae_lvl), .af_lvl(af_lvl),
    .txudf_pulse(txudf_pulse), .rxovf_pulse(rxovf_pulse), .wake_pulse(wake_pulse),
    .word_done(word_done), .wcnt_wr(wcnt_wr), .wcnt_wdata(wcnt_wdata),
    .evt_wr(evt_wr), .evt_wdata(evt_wdata), .evt_en(evt_en),
    .tx_req(tx_req), .rx_req(rx_req), .evt_status(evt_status), .irq(irq),
    .wcnt_rd(wcnt_rd));

  task automatic chk(string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0d exp=%0d", what, got, exp);
    end
  endtask

  function automatic bit exp_rx(bit en, int lvl, int af);
    return en && (lvl >= af + 1);
  endfunction

  function automatic bit exp_tx(bit en, int lvl, int ae);
    return en && ((DEPTH - lvl) >= ae + 1);
  endfunction

  function automatic int exp_rd();
    return m_run ? m_idx : m_prog;
  endfunction

  task automatic idle_inputs();
    txudf_pulse = 0; rxovf_pulse = 0; wake_pulse = 0; word_done = 0;
    wcnt_wr = 0; evt_wr = 0; evt_wdata = '0;
  endtask

  // Inputs are set after a negedge; evaluate, clock, then compare.
  task automatic cyc();
    bit tc, rc, eow;
    logic [5:0] setv, clr;
    #1;
    tc = exp_tx(chan_en, int'(tx_level), int'(ae_lvl));
    rc = exp_rx(chan_en, int'(rx_level), int'(af_lvl));
    chk("R1 rx_req", int'(rx_req), int'(rc));
    chk("R2 tx_req", int'(tx_req), int'(tc));
    eow = chan_en && word_done && !wcnt_wr && (m_prog != 0) &&
          (m_idx < m_prog) && (m_idx + 1 == m_prog);
    setv = {eow, wake_pulse, rxovf_pulse, rc && !m_rxc_q, txudf_pulse, tc && !m_txc_q};
    clr  = evt_wr ? evt_wdata : 6'b0;
    m_sts = (m_sts & ~clr) | setv;
    m_txc_q = tc;
    m_rxc_q = rc;
    if (wcnt_wr) begin
      m_prog = int'(wcnt_wdata); m_idx = 0; m_run = 0;
    end else if (!chan_en) begin
      m_idx = 0; m_run = 0;
    end else if (word_done && m_prog != 0 && m_idx < m_prog) begin
      m_idx++; m_run = 1;
    end
    @(posedge clk);
    #1;
    chk("R3 R4 R10 evt_status", int'(evt_status), int'(m_sts));
    chk("R5 irq", int'(irq), int'(|(m_sts & evt_en)));
    chk("R7 wcnt_rd", int'(wcnt_rd), exp_rd());
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; chan_en = 0; tx_level = '0; rx_level = '0;
    ae_lvl = '0; af_lvl = '0; wcnt_wdata = '0; evt_en = '0;
    idle_inputs();
    m_sts = '0; m_txc_q = 0; m_rxc_q = 0; m_run = 0; m_prog = 0; m_idx = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R11
    chk("R11 reset status", int'(evt_status), 0);
    chk("R11 reset irq", int'(irq), 0);
    chk("R11 reset wcnt_rd", int'(wcnt_rd), 0);

    // R1 / R2 thresholds at n-1 and n
    chan_en = 1; tx_level = OCC_W'(DEPTH); ae_lvl = 8'd0; rx_level = 3; af_lvl = 8'd3;
    cyc();
    chk("R1 below level", int'(rx_req), 0);
    chk("R2 no room", int'(tx_req), 0);
    rx_level = 4; tx_level = OCC_W'(DEPTH - 1);
    cyc();
    chk("R1 at level", int'(rx_req), 1);
    chk("R2 room one", int'(tx_req), 1);
    chk("R3 rise sets bits", int'(evt_status & 6'b000101), 5);
    // R3 clear with condition held: no re-set; R4 zero bits untouched
    evt_wr = 1; evt_wdata = 6'b000100;
    cyc();
    cyc();
    chk("R3 held no reset", int'(evt_status[2]), 0);
    chk("R4 zero bit kept", int'(evt_status[0]), 1);
    // R4 set wins over clear
    rx_level = 0; cyc();
    rx_level = 4; evt_wr = 1; evt_wdata = 6'b000100;
    cyc();
    chk("R4 set wins", int'(evt_status[2]), 1);
    evt_wr = 1; evt_wdata = 6'b111111; cyc();
    // R10 external pulses
    txudf_pulse = 1; cyc();
    chk("R10 underflow bit1", int'(evt_status[1]), 1);
    rxovf_pulse = 1; wake_pulse = 1; cyc();
    chk("R10 ovf wake bits", int'(evt_status[4:3]), 3);
    // R5 enables
    evt_en = 6'b000010; cyc();
    chk("R5 irq enabled", int'(irq), 1);
    evt_wr = 1; evt_wdata = 6'b000010; cyc();
    chk("R5 irq after clear", int'(irq), 0);
    // R6 zero total
    evt_wr = 1; evt_wdata = 6'b111111; cyc();
    repeat (3) begin word_done = 1; cyc(); end
    chk("R6 zero total rd", int'(wcnt_rd), 0);
    chk("R6 zero total no eow", int'(evt_status[5]), 0);
    // R7 / R8 count of three
    wcnt_wr = 1; wcnt_wdata = 3; cyc();
    chk("R7 programmed rd", int'(wcnt_rd), 3);
    word_done = 1; cyc();
    chk("R7 live index", int'(wcnt_rd), 1);
    word_done = 1; cyc();
    chk("R8 before end no eow", int'(evt_status[5]), 0);
    word_done = 1; cyc();
    chk("R8 eow set", int'(evt_status[5]), 1);
    word_done = 1; cyc();
    chk("R8 index holds", int'(wcnt_rd), 3);
    // R9 disable and rewrite
    chan_en = 0; cyc();
    chan_en = 1; word_done = 1; cyc();
    chk("R9 restart after disable", int'(wcnt_rd), 1);
    wcnt_wr = 1; wcnt_wdata = 2; word_done = 1; cyc();
    chk("R9 rewrite wins", int'(wcnt_rd), 2);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 40) == 0) chan_en = ~chan_en;
      tx_level = OCC_W'($urandom_range(0, DEPTH));
      rx_level = OCC_W'($urandom_range(0, DEPTH));
      if ($urandom_range(0, 20) == 0) ae_lvl = 8'($urandom_range(0, 40));
      if ($urandom_range(0, 20) == 0) af_lvl = 8'($urandom_range(0, 40));
      word_done   = ($urandom_range(0, 2) == 0);
      txudf_pulse = ($urandom_range(0, 15) == 0);
      rxovf_pulse = ($urandom_range(0, 15) == 0);
      wake_pulse  = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 30) == 0) begin
        wcnt_wr = 1; wcnt_wdata = CNT_W'($urandom_range(0, 6));
      end
      if ($urandom_range(0, 3) == 0) begin
        evt_wr = 1; evt_wdata = 6'($urandom_range(0, 63));
      end
      if ($urandom_range(0, 25) == 0) evt_en = 6'($urandom_range(0, 63));
      cyc();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
  end
endmodule